// File: doc/BRIEF.md
# Prioritised DMA Channel Arbiter with Transfer Accounting

This block picks which of seven DMA channels owns the next transfer slot and keeps per-channel transfer accounting. Every channel carries an enable, a two-bit priority level, a programmed transfer count with a live remaining count, a circular (auto-reload) option, three sticky event flags (half, complete, error) and an interrupt enable for each flag. A channel takes part in arbitration when it is enabled, its request line is high and its remaining count is non-zero.

The arbiter makes a choice only when no transfer is in flight. It registers the winner and holds the grant until the bus side reports the transfer as finished, either successfully or with an error. A successful transfer decrements the remaining count. That can set the half flag or the complete flag, and then either reloads the count (circular mode) or disables the channel. An error sets the error flag and disables the channel. Flags are cleared by write-one-to-clear strobes. Each channel drives an interrupt line that is the OR of its set flags whose enables are on.

Top module: `dma_chan_arb`

## Requirements
- R1: After reset `grantValid`, `chEnable`, all flags and `irq` are 0.
- R2: Among eligible channels, one with a higher priority level wins. Level 3 is the highest and level 0 the lowest.
- R3: Among eligible channels at the same level, the lowest channel index wins.
- R4: A grant is made only when no grant is active. `grantValid` and `grantCh` then stay stable until `xferDone` or `xferErr` is seen, and `grantValid` is 0 in the cycle after that.
- R5: Eligibility requires all three of: enable bit 1, `req` bit 1, and remaining count non-zero. A channel becomes eligible in the cycle after a configuration write that sets its enable.
- R6: A successful transfer (`xferDone` without `xferErr`) decrements the granted channel's remaining count by one.
- R7: `flagHalf[i]` sets when a successful transfer leaves the remaining count equal to the programmed count shifted right by one.
- R8: `flagDone[i]` sets when a successful transfer leaves the remaining count at 0. A non-circular channel then clears its enable and is granted no more.
- R9: A circular channel that reaches 0 reloads the programmed count, stays enabled and keeps being granted.
- R10: `xferErr` during a grant sets `flagErr[i]`, clears the enable and leaves the remaining count unchanged. `xferErr` takes precedence over `xferDone`.
- R11: A 1 on bit i of `clrHalf`, `clrDone` or `clrErr` clears that flag of channel i. If a set and a clear hit the same flag in the same cycle, the set wins.
- R12: `irq[i]` is (`flagHalf` AND half-enable) OR (`flagDone` AND done-enable) OR (`flagErr` AND error-enable) for channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write the configuration fields below into channel `cfgCh` |
| cfgCh | input | 3 | Channel index for the configuration write |
| cfgEnable | input | 1 | Enable bit |
| cfgPrio | input | 2 | Priority level (3 highest) |
| cfgCount | input | 16 | Programmed count; also loads the remaining count |
| cfgCirc | input | 1 | Circular reload mode |
| cfgIeHalf | input | 1 | Half-flag interrupt enable |
| cfgIeDone | input | 1 | Complete-flag interrupt enable |
| cfgIeErr | input | 1 | Error-flag interrupt enable |
| clrHalf | input | 7 | Write-one-to-clear half flags, bit i = channel i |
| clrDone | input | 7 | Write-one-to-clear complete flags |
| clrErr | input | 7 | Write-one-to-clear error flags |
| req | input | 7 | Peripheral request per channel |
| xferDone | input | 1 | Granted transfer finished successfully |
| xferErr | input | 1 | Granted transfer finished with error |
| grantValid | output | 1 | A transfer slot is granted |
| grantCh | output | 3 | Granted channel index |
| chEnable | output | 7 | Current enable bit per channel |
| remFlat | output | 112 | Remaining counts, channel i in bits [16i+15:16i] |
| flagHalf | output | 7 | Half-transfer flags |
| flagDone | output | 7 | Transfer-complete flags |
| flagErr | output | 7 | Transfer-error flags |
| irq | output | 7 | Per-channel interrupt |

## Verification
The bench targets the mixed case where one channel at a lower index but a lower level competes with two channels that tie at a higher level. A comparator with the wrong direction or the wrong tie order would grant channel 1 or channel 6 instead of channel 5. It also targets the last transfer of a non-circular channel: a design that failed to disable there would grant the channel again at count 0, and one that reloaded only circular channels wrongly would stall a circular one. An error that left the enable set would show up as a repeated grant, and an error that decremented the count would show up as a wrong remaining value. Applying the clear over a simultaneous set would show up as a lost complete flag.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int MAX_CH_W = 4;

  // Strobes from the arbitration control to the channel datapath.
  typedef struct packed {
    logic                doneOk;
    logic                doneErr;
    logic [MAX_CH_W-1:0] ch;
  } arbStrobe_t;
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int PRIO_W = 2,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        eligible,
  input  logic [NUM_CH*PRIO_W-1:0] prioFlat,
  input  logic                     xferDone,
  input  logic                     xferErr,
  output logic                     grantValid,
  output logic [CH_W-1:0]          grantCh,
  output arbStrobe_t               strb
);
  logic              found;
  logic [CH_W-1:0]   bestCh;
  logic [PRIO_W-1:0] bestPrio;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    found    = 1'b0;
    bestCh   = '0;
    bestPrio = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i] && (!found || prioFlat[i*PRIO_W +: PRIO_W] >= bestPrio)) begin
        found    = 1'b1;
        bestCh   = CH_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantCh    <= '0;
    end else if (grantValid) begin
      if (xferDone || xferErr) grantValid <= 1'b0;
    end else if (found) begin
      grantValid <= 1'b1;
      grantCh    <= bestCh;
    end
  end

  always_comb begin
    strb.doneErr = grantValid && xferErr;
    strb.doneOk  = grantValid && xferDone && !xferErr;
    strb.ch      = MAX_CH_W'(grantCh);
  end
endmodule

// File: rtl/dma_arb_chan_regs.sv
module dma_arb_chan_regs
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int PRIO_W = 2,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [CH_W-1:0]          cfgCh,
  input  logic                     cfgEnable,
  input  logic [PRIO_W-1:0]        cfgPrio,
  input  logic [CNT_W-1:0]         cfgCount,
  input  logic                     cfgCirc,
  input  logic                     cfgIeHalf,
  input  logic                     cfgIeDone,
  input  logic                     cfgIeErr,
  input  logic [NUM_CH-1:0]        clrHalf,
  input  logic [NUM_CH-1:0]        clrDone,
  input  logic [NUM_CH-1:0]        clrErr,
  input  logic [NUM_CH-1:0]        req,
  input  arbStrobe_t               strb,
  output logic [NUM_CH-1:0]        eligible,
  output logic [NUM_CH*PRIO_W-1:0] prioFlat,
  output logic [NUM_CH-1:0]        chEnable,
  output logic [NUM_CH*CNT_W-1:0]  remFlat,
  output logic [NUM_CH-1:0]        flagHalf,
  output logic [NUM_CH-1:0]        flagDone,
  output logic [NUM_CH-1:0]        flagErr,
  output logic [NUM_CH-1:0]        irq
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic              en, circ, ieH, ieD, ieE, fH, fD, fE;
    logic [PRIO_W-1:0] prio;
    logic [CNT_W-1:0]  prog, rem, remDec;
    logic              cfgHit, okHit, errHit, setHalf, setDone;

    assign cfgHit  = cfgWe && (cfgCh == CH_W'(g));
    assign okHit   = strb.doneOk && (strb.ch == MAX_CH_W'(g)) && (rem != '0);
    assign errHit  = strb.doneErr && (strb.ch == MAX_CH_W'(g));
    assign remDec  = rem - CNT_W'(1);
    assign setHalf = okHit && (remDec == (prog >> 1));
    assign setDone = okHit && (remDec == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        en <= 1'b0; circ <= 1'b0; ieH <= 1'b0; ieD <= 1'b0; ieE <= 1'b0;
        prio <= '0; prog <= '0; rem <= '0;
      end else if (cfgHit) begin
        en   <= cfgEnable;
        circ <= cfgCirc;
        ieH  <= cfgIeHalf;
        ieD  <= cfgIeDone;
        ieE  <= cfgIeErr;
        prio <= cfgPrio;
        prog <= cfgCount;
        rem  <= cfgCount;
      end else if (errHit) begin
        en <= 1'b0;
      end else if (okHit) begin
        if (remDec == '0) begin
          if (circ) rem <= prog;
          else begin
            rem <= '0;
            en  <= 1'b0;
          end
        end else begin
          rem <= remDec;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        fH <= 1'b0; fD <= 1'b0; fE <= 1'b0;
      end else begin
        fH <= (fH && !clrHalf[g]) || setHalf;
        fD <= (fD && !clrDone[g]) || setDone;
        fE <= (fE && !clrErr[g])  || errHit;
      end
    end

    assign eligible[g]                   = en && req[g] && (rem != '0);
    assign prioFlat[g*PRIO_W +: PRIO_W]  = prio;
    assign chEnable[g]                   = en;
    assign remFlat[g*CNT_W +: CNT_W]     = rem;
    assign flagHalf[g]                   = fH;
    assign flagDone[g]                   = fD;
    assign flagErr[g]                    = fE;
    assign irq[g]                        = (fH && ieH) || (fD && ieD) || (fE && ieE);
  end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int PRIO_W = 2,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [CH_W-1:0]         cfgCh,
  input  logic                    cfgEnable,
  input  logic [PRIO_W-1:0]       cfgPrio,
  input  logic [CNT_W-1:0]        cfgCount,
  input  logic                    cfgCirc,
  input  logic                    cfgIeHalf,
  input  logic                    cfgIeDone,
  input  logic                    cfgIeErr,
  input  logic [NUM_CH-1:0]       clrHalf,
  input  logic [NUM_CH-1:0]       clrDone,
  input  logic [NUM_CH-1:0]       clrErr,
  input  logic [NUM_CH-1:0]       req,
  input  logic                    xferDone,
  input  logic                    xferErr,
  output logic                    grantValid,
  output logic [CH_W-1:0]         grantCh,
  output logic [NUM_CH-1:0]       chEnable,
  output logic [NUM_CH*CNT_W-1:0] remFlat,
  output logic [NUM_CH-1:0]       flagHalf,
  output logic [NUM_CH-1:0]       flagDone,
  output logic [NUM_CH-1:0]       flagErr,
  output logic [NUM_CH-1:0]       irq
);
  logic [NUM_CH-1:0]        eligible;
  logic [NUM_CH*PRIO_W-1:0] prioFlat;
  arbStrobe_t               strb;

  dma_arb_ctrl #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .prioFlat(prioFlat),
    .xferDone(xferDone), .xferErr(xferErr),
    .grantValid(grantValid), .grantCh(grantCh), .strb(strb)
  );

  dma_arb_chan_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh),
    .cfgEnable(cfgEnable), .cfgPrio(cfgPrio), .cfgCount(cfgCount),
    .cfgCirc(cfgCirc), .cfgIeHalf(cfgIeHalf), .cfgIeDone(cfgIeDone),
    .cfgIeErr(cfgIeErr), .clrHalf(clrHalf), .clrDone(clrDone),
    .clrErr(clrErr), .req(req), .strb(strb), .eligible(eligible),
    .prioFlat(prioFlat), .chEnable(chEnable), .remFlat(remFlat),
    .flagHalf(flagHalf), .flagDone(flagDone), .flagErr(flagErr), .irq(irq)
  );
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk #(
  parameter int NUM_CH = 7,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [CH_W-1:0]   cfgCh,
  input logic [NUM_CH-1:0] req,
  input logic              xferDone,
  input logic              xferErr,
  input logic              grantValid,
  input logic [CH_W-1:0]   grantCh,
  input logic [NUM_CH-1:0] chEnable,
  input logic [NUM_CH-1:0] flagHalf,
  input logic [NUM_CH-1:0] flagDone,
  input logic [NUM_CH-1:0] flagErr,
  input logic [NUM_CH-1:0] irq
);
  assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !xferDone && !xferErr |=> grantValid && $stable(grantCh));

  assert_grant_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && (xferDone || xferErr) |=> !grantValid);

  assert_grant_eligible_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> ((($past(req) & $past(chEnable)) >> grantCh) & NUM_CH'(1)) != '0);

  assert_err_disables_R10: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && xferErr && !(cfgWe && cfgCh == grantCh)
    |=> ((chEnable >> $past(grantCh)) & NUM_CH'(1)) == '0);

  assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~(flagHalf | flagDone | flagErr)) == '0);

  assert_grant_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> int'(grantCh) < NUM_CH);
endmodule

bind dma_chan_arb dma_chan_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .req(req),
  .xferDone(xferDone), .xferErr(xferErr), .grantValid(grantValid),
  .grantCh(grantCh), .chEnable(chEnable), .flagHalf(flagHalf),
  .flagDone(flagDone), .flagErr(flagErr), .irq(irq)
);

// File: tb/dma_chan_arb_bench.sv
module dma_chan_arb_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [2:0]  cfgCh;
  logic        cfgEnable;
  logic [1:0]  cfgPrio;
  logic [15:0] cfgCount;
  logic        cfgCirc, cfgIeHalf, cfgIeDone, cfgIeErr;
  logic [6:0]  clrHalf, clrDone, clrErr, req;
  logic        xferDone, xferErr;
  logic        grantValid;
  logic [2:0]  grantCh;
  logic [6:0]  chEnable, flagHalf, flagDone, flagErr, irq;
  logic [111:0] remFlat;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dma_chan_arb u_dma_chan_arb (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh),
    .cfgEnable(cfgEnable), .cfgPrio(cfgPrio), .cfgCount(cfgCount),
    .cfgCirc(cfgCirc), .cfgIeHalf(cfgIeHalf), .cfgIeDone(cfgIeDone),
    .cfgIeErr(cfgIeErr), .clrHalf(clrHalf), .clrDone(clrDone),
    .clrErr(clrErr), .req(req), .xferDone(xferDone), .xferErr(xferErr),
    .grantValid(grantValid), .grantCh(grantCh), .chEnable(chEnable),
    .remFlat(remFlat), .flagHalf(flagHalf), .flagDone(flagDone),
    .flagErr(flagErr), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int remOf(input int ch);
    return int'(remFlat[ch*16 +: 16]);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cfgWe = 1'b0; cfgCh = '0; cfgEnable = 1'b0; cfgPrio = '0;
    cfgCount = '0; cfgCirc = 1'b0; cfgIeHalf = 1'b0; cfgIeDone = 1'b0;
    cfgIeErr = 1'b0; clrHalf = '0; clrDone = '0; clrErr = '0; req = '0;
    xferDone = 1'b0; xferErr = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic cfgWrite(input int ch, input bit en, input int prio, input int cnt,
                          input bit circ, input bit ieH, input bit ieD, input bit ieE);
    cfgWe = 1'b1; cfgCh = 3'(ch); cfgEnable = en; cfgPrio = 2'(prio);
    cfgCount = 16'(cnt); cfgCirc = circ; cfgIeHalf = ieH; cfgIeDone = ieD;
    cfgIeErr = ieE;
    tick();
    cfgWe = 1'b0;
  endtask

  // One cycle later the next grant is visible.
  task automatic expectGrant(input int ch, input string tag);
    tick();
    check(grantValid && grantCh == 3'(ch), tag, grantValid ? int'(grantCh) : -1, ch);
  endtask

  task automatic finish(input bit isErr);
    xferDone = !isErr; xferErr = isErr;
    tick();
    xferDone = 1'b0; xferErr = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(!grantValid, "R1 grantValid", int'(grantValid), 0);
    check(chEnable == '0, "R1 chEnable", int'(chEnable), 0);
    check((flagHalf | flagDone | flagErr) == '0, "R1 flags",
          int'(flagHalf | flagDone | flagErr), 0);
    check(irq == '0, "R1 irq", int'(irq), 0);
  endtask

  task automatic testPriority();
    doReset();
    cfgWrite(1, 1, 1, 8, 0, 0, 0, 0);
    cfgWrite(5, 1, 3, 8, 0, 0, 0, 0);
    cfgWrite(6, 1, 3, 8, 0, 0, 0, 0);
    req = 7'b1100010;
    expectGrant(5, "R2 R3 level then low index");
    tick(); tick(); tick();
    check(grantValid && grantCh == 3'd5, "R4 grant held", int'(grantCh), 5);
    finish(0);
    check(!grantValid, "R4 release after done", int'(grantValid), 0);
    check(remOf(5) == 7, "R6 decrement", remOf(5), 7);
    req = 7'b1000010;
    expectGrant(6, "R3 next tied channel");
    finish(0);
    req = 7'b0000010;
    expectGrant(1, "R2 lower level served last");
    finish(0);
  endtask

  task automatic testEligibility();
    doReset();
    cfgWrite(2, 0, 3, 4, 0, 0, 0, 0);
    cfgWrite(3, 1, 3, 0, 0, 0, 0, 0);
    cfgWrite(4, 1, 0, 4, 0, 0, 0, 0);
    req = 7'b0011100;
    expectGrant(4, "R5 disabled and zero-count skipped");
    finish(0);
    req = 7'b0001100;
    tick(); tick();
    check(!grantValid, "R5 no eligible channel", int'(grantValid), 0);
  endtask

  task automatic testHalfDone();
    doReset();
    cfgWrite(0, 1, 2, 4, 0, 1, 0, 0);
    req = 7'b0000001;
    expectGrant(0, "R5 grant after enable");
    finish(0);
    check(!flagHalf[0] && remOf(0) == 3, "R7 no half yet", remOf(0), 3);
    expectGrant(0, "R8 still serving");
    finish(0);
    check(flagHalf[0], "R7 half flag", int'(flagHalf[0]), 1);
    check(irq[0], "R12 half irq", int'(irq[0]), 1);
    expectGrant(0, "R8 third");
    finish(0);
    expectGrant(0, "R8 fourth");
    finish(0);
    check(flagDone[0] && !chEnable[0], "R8 done and disabled",
          int'({flagDone[0], chEnable[0]}), 2);
    tick(); tick();
    check(!grantValid, "R8 no grant after completion", int'(grantValid), 0);
    clrHalf = 7'b0000001;
    tick();
    clrHalf = '0;
    check(!flagHalf[0] && flagDone[0], "R11 clear only half",
          int'({flagHalf[0], flagDone[0]}), 1);
    check(!irq[0], "R12 masked done flag", int'(irq[0]), 0);
  endtask

  task automatic testCircular();
    doReset();
    cfgWrite(3, 1, 1, 2, 1, 0, 1, 0);
    req = 7'b0001000;
    expectGrant(3, "R9 first");
    finish(0);
    expectGrant(3, "R9 second");
    finish(0);
    check(remOf(3) == 2 && chEnable[3], "R9 reload", remOf(3), 2);
    check(flagDone[3] && irq[3], "R12 done irq", int'(irq[3]), 1);
    clrDone = 7'b0001000;
    tick();
    clrDone = '0;
    check(!flagDone[3], "R11 clear done", int'(flagDone[3]), 0);
    expectGrant(3, "R9 keeps serving");
    finish(0);
    expectGrant(3, "R9 again");
    xferDone = 1'b1; clrDone = 7'b0001000;
    tick();
    xferDone = 1'b0; clrDone = '0;
    check(flagDone[3], "R11 set wins over clear", int'(flagDone[3]), 1);
  endtask

  task automatic testError();
    doReset();
    cfgWrite(2, 1, 0, 5, 0, 0, 0, 1);
    req = 7'b0000100;
    expectGrant(2, "R10 first");
    finish(0);
    expectGrant(2, "R10 second");
    xferDone = 1'b1;
    finish(1);
    check(flagErr[2] && !chEnable[2], "R10 error disables",
          int'({flagErr[2], chEnable[2]}), 2);
    check(remOf(2) == 4, "R10 count kept", remOf(2), 4);
    check(irq[2], "R12 error irq", int'(irq[2]), 1);
    tick(); tick();
    check(!grantValid, "R10 no grant after error", int'(grantValid), 0);
    clrErr = 7'b0000100;
    tick();
    clrErr = '0;
    check(!flagErr[2] && !irq[2], "R11 clear error", int'(flagErr[2]), 0);
  endtask

  initial begin
    rstN = 1'b0;
    testReset();
    testPriority();
    testEligibility();
    testHalfDone();
    testCircular();
    testError();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule